// File: doc/BRIEF.md
# Camera Stream Window and Channel Filter

This block sits after a camera serial-link packet decoder. Every input beat carries a pixel together with its virtual channel number (0 to 3), a packet class index, a frame-start flag and a line-start flag. The block drops a beat unless its channel is enabled and its packet class is enabled. For each channel it tracks the column and row of the beats it accepts, and it forwards a pixel only when that pixel lies inside a programmed rectangle. The rectangle's end coordinates are inclusive.

Frame sync and line sync for the downstream path come from one channel each. Two separate one-hot masks choose those channels. The sync outputs mark the first and last forwarded pixel of the window and of each window line.

A write-only register port sets the configuration. It covers a soft reset, a clock enable, the channel and class enables, the two window registers and the sync source masks. The datapath is held idle while the soft reset is set or while the clock enable is clear.

Top module: `cam_win_filter`

## Requirements
- R1: After `rst_ni` is released, all outputs are 0. Every register resets to 0, so the clock enable is clear and no beat is forwarded until software sets it.
- R2: Register word 1 bits 3:0 enable channels 0 to 3, with bit 0 enabling channel 0. A beat on a disabled channel is dropped and does not advance that channel's position.
- R3: Register word 1 bits 20:16 enable packet classes 0 to 4, with bit 16 enabling class 0 (RAW) and bit 17 enabling class 1 (YUV). A beat whose class is disabled, or whose class index is 5 to 7, is dropped.
- R4: Register word 2 holds the column start in bits 15:0 and the inclusive column end in bits 31:16. Register word 3 holds the row window in the same layout. A pixel is forwarded only when start <= column <= end and start <= row <= end.
- R5: Each channel keeps its own position. A beat with the frame-start flag is at column 0, row 0. A beat with the line-start flag is at column 0 on the next row. Any other beat is one column to the right of the channel's previous accepted beat. Accepted beats on a channel before its first frame start are not forwarded.
- R6: Register word 4 bits 19:16 form a frame-sync mask, with bit 16 selecting channel 0. `out_fs_o` marks the forwarded pixel at (column start, row start) of the selected channel. `out_fe_o` marks the forwarded pixel at (column end, row end).
- R7: Register word 4 bits 23:20 form a line-sync mask with the same channel order. `out_ls_o` marks each forwarded pixel at the column start of the selected channel. `out_le_o` marks each forwarded pixel at the column end.
- R8: A sync mask with no bit set, or with more than one bit set, produces no sync pulse of that kind. Pixel forwarding is not affected.
- R9: Register word 0 bit 0 is a soft reset and bit 1 is a clock enable. While the soft reset is set, or while the clock enable is clear, nothing is forwarded. The soft reset also clears every channel's frame state, so forwarding resumes only after a new frame start. While only the clock enable is clear, the positions hold.
- R10: A forwarded pixel appears one clock after its input beat, with unchanged data and channel number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index (0 control, 1 enables, 2 column window, 3 row window, 4 sync masks) |
| reg_wdata_i | input | 32 | Register write data |
| in_valid_i | input | 1 | Input beat valid |
| in_vc_i | input | 2 | Virtual channel of the beat |
| in_cls_i | input | 3 | Packet class index of the beat |
| in_sof_i | input | 1 | Beat is the first pixel of a frame |
| in_sol_i | input | 1 | Beat is the first pixel of a line |
| in_data_i | input | DATA_W | Pixel data |
| out_valid_o | output | 1 | Forwarded pixel valid |
| out_vc_o | output | 2 | Channel of the forwarded pixel |
| out_data_o | output | DATA_W | Forwarded pixel data |
| out_fs_o | output | 1 | First pixel of the window |
| out_fe_o | output | 1 | Last pixel of the window |
| out_ls_o | output | 1 | First pixel of a window line |
| out_le_o | output | 1 | Last pixel of a window line |

## Verification
Every output for an input beat is due exactly one rising edge after that beat is sampled. A register write takes effect for the beat driven in the following cycle. The bench drives each beat on a falling edge and compares all outputs on the next falling edge. Its own position model predicts forwarding and sync for that single beat, so each comparison matches one beat to its one result, and idle cycles and register writes fall between beats without shifting that pairing.

// File: rtl/cwf_pkg.sv
`timescale 1ns/1ps
package cwf_pkg;
  localparam int NUM_VC   = 4;
  localparam int VC_W     = $clog2(NUM_VC);
  localparam int NUM_CLS  = 5;
  localparam int CLS_W    = 3;
  localparam int CLS_SPAN = 1 << CLS_W;
  localparam int COORD_W  = 16;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 3;

  localparam int CTRL_SRST_BIT = 0;
  localparam int CTRL_CLKEN_BIT = 1;
  localparam int GEN_CLS_LSB   = 16;
  localparam int SYNC_FS_LSB   = 16;
  localparam int SYNC_LS_LSB   = 20;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL = 3'd0,
    ADDR_GEN  = 3'd1,
    ADDR_XWIN = 3'd2,
    ADDR_YWIN = 3'd3,
    ADDR_SYNC = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic                 sw_rst;
    logic                 clk_en;
    logic [NUM_VC-1:0]    ch_en;
    logic [NUM_CLS-1:0]   cls_en;
    logic [COORD_W-1:0]   x_start;
    logic [COORD_W-1:0]   x_end;
    logic [COORD_W-1:0]   y_start;
    logic [COORD_W-1:0]   y_end;
    logic [NUM_VC-1:0]    fs_mask;
    logic [NUM_VC-1:0]    ls_mask;
  } cfg_t;
endpackage

// File: rtl/cwf_regs.sv
`timescale 1ns/1ps
module cwf_regs
  import cwf_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output cfg_t              cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        ADDR_CTRL: begin
          cfg_q.sw_rst <= wdata_i[CTRL_SRST_BIT];
          cfg_q.clk_en <= wdata_i[CTRL_CLKEN_BIT];
        end
        ADDR_GEN: begin
          cfg_q.ch_en  <= wdata_i[NUM_VC-1:0];
          cfg_q.cls_en <= wdata_i[GEN_CLS_LSB +: NUM_CLS];
        end
        ADDR_XWIN: begin
          cfg_q.x_start <= wdata_i[COORD_W-1:0];
          cfg_q.x_end   <= wdata_i[COORD_W +: COORD_W];
        end
        ADDR_YWIN: begin
          cfg_q.y_start <= wdata_i[COORD_W-1:0];
          cfg_q.y_end   <= wdata_i[COORD_W +: COORD_W];
        end
        ADDR_SYNC: begin
          cfg_q.fs_mask <= wdata_i[SYNC_FS_LSB +: NUM_VC];
          cfg_q.ls_mask <= wdata_i[SYNC_LS_LSB +: NUM_VC];
        end
        default: ;
      endcase
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/cwf_pos.sv
`timescale 1ns/1ps
module cwf_pos
  import cwf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               adv_i,
  input  logic               sof_i,
  input  logic               sol_i,
  output logic [COORD_W-1:0] col_o,
  output logic [COORD_W-1:0] row_o,
  output logic               live_o
);
  logic [COORD_W-1:0] col_q, row_q;
  logic               frame_q;

  // position of the beat currently presented
  always_comb begin
    if (sof_i) begin
      col_o = '0;
      row_o = '0;
    end else if (sol_i) begin
      col_o = '0;
      row_o = row_q + 1'b1;
    end else begin
      col_o = col_q + 1'b1;
      row_o = row_q;
    end
  end

  assign live_o = sof_i | frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      row_q   <= '0;
      frame_q <= 1'b0;
    end else if (clr_i) begin
      col_q   <= '0;
      row_q   <= '0;
      frame_q <= 1'b0;
    end else if (adv_i) begin
      col_q <= col_o;
      row_q <= row_o;
      if (sof_i) frame_q <= 1'b1;
    end
  end
endmodule

// File: rtl/cwf_out.sv
`timescale 1ns/1ps
module cwf_out
  import cwf_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  cfg_t               cfg_i,
  input  logic               acc_i,
  input  logic [VC_W-1:0]    vc_i,
  input  logic [COORD_W-1:0] col_i,
  input  logic [COORD_W-1:0] row_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               valid_o,
  output logic [VC_W-1:0]    vc_o,
  output logic [DATA_W-1:0]  data_o,
  output logic               fs_o,
  output logic               fe_o,
  output logic               ls_o,
  output logic               le_o
);
  logic in_x, in_y, fwd;
  logic fs_src, ls_src;
  logic col_first, col_last, row_first, row_last;

  assign in_x = (col_i >= cfg_i.x_start) && (col_i <= cfg_i.x_end);
  assign in_y = (row_i >= cfg_i.y_start) && (row_i <= cfg_i.y_end);
  assign fwd  = acc_i && in_x && in_y;

  // a mask that is not one-hot selects no source
  assign fs_src = $onehot(cfg_i.fs_mask) && cfg_i.fs_mask[vc_i];
  assign ls_src = $onehot(cfg_i.ls_mask) && cfg_i.ls_mask[vc_i];

  assign col_first = (col_i == cfg_i.x_start);
  assign col_last  = (col_i == cfg_i.x_end);
  assign row_first = (row_i == cfg_i.y_start);
  assign row_last  = (row_i == cfg_i.y_end);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vc_o    <= '0;
      data_o  <= '0;
      fs_o    <= 1'b0;
      fe_o    <= 1'b0;
      ls_o    <= 1'b0;
      le_o    <= 1'b0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
      fs_o    <= 1'b0;
      fe_o    <= 1'b0;
      ls_o    <= 1'b0;
      le_o    <= 1'b0;
    end else begin
      valid_o <= fwd;
      fs_o    <= fwd && fs_src && col_first && row_first;
      fe_o    <= fwd && fs_src && col_last && row_last;
      ls_o    <= fwd && ls_src && col_first;
      le_o    <= fwd && ls_src && col_last;
      if (fwd) begin
        vc_o   <= vc_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/cam_win_filter.sv
`timescale 1ns/1ps
module cam_win_filter
  import cwf_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  input  logic              in_valid_i,
  input  logic [1:0]        in_vc_i,
  input  logic [2:0]        in_cls_i,
  input  logic              in_sof_i,
  input  logic              in_sol_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [1:0]        out_vc_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_fs_o,
  output logic              out_fe_o,
  output logic              out_ls_o,
  output logic              out_le_o
);
  cfg_t cfg;

  cwf_regs u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cfg_o   (cfg)
  );

  logic                stream_en;
  logic [CLS_SPAN-1:0] cls_ext;
  logic                acc_beat;

  assign stream_en = cfg.clk_en && !cfg.sw_rst;
  assign cls_ext   = CLS_SPAN'(cfg.cls_en);
  assign acc_beat  = in_valid_i && stream_en && cfg.ch_en[in_vc_i] && cls_ext[in_cls_i];

  logic [COORD_W-1:0] col_w  [NUM_VC];
  logic [COORD_W-1:0] row_w  [NUM_VC];
  logic [NUM_VC-1:0]  live_w;

  for (genvar c = 0; c < NUM_VC; c++) begin : g_pos
    cwf_pos u_pos (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (cfg.sw_rst),
      .adv_i  (acc_beat && (in_vc_i == VC_W'(c))),
      .sof_i  (in_sof_i),
      .sol_i  (in_sol_i),
      .col_o  (col_w[c]),
      .row_o  (row_w[c]),
      .live_o (live_w[c])
    );
  end

  cwf_out #(.DATA_W(DATA_W)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (cfg.sw_rst),
    .cfg_i   (cfg),
    .acc_i   (acc_beat && live_w[in_vc_i]),
    .vc_i    (in_vc_i),
    .col_i   (col_w[in_vc_i]),
    .row_i   (row_w[in_vc_i]),
    .data_i  (in_data_i),
    .valid_o (out_valid_o),
    .vc_o    (out_vc_o),
    .data_o  (out_data_o),
    .fs_o    (out_fs_o),
    .fe_o    (out_fe_o),
    .ls_o    (out_ls_o),
    .le_o    (out_le_o)
  );
endmodule

// File: rtl/cwf_chk.sv
`timescale 1ns/1ps
module cwf_chk
  import cwf_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input cfg_t              cfg_i,
  input logic              in_valid_i,
  input logic [1:0]        in_vc_i,
  input logic [2:0]        in_cls_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              out_valid_o,
  input logic [1:0]        out_vc_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_fs_o,
  input logic              out_fe_o,
  input logic              out_ls_o,
  input logic              out_le_o
);
  assert_sync_on_pixel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fs_o || out_fe_o || out_ls_o || out_le_o) |-> out_valid_o);

  assert_drop_disabled_ch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(cfg_i.ch_en[in_vc_i]));

  assert_class_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(in_cls_i) < 3'(NUM_CLS)));

  assert_halt_when_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(cfg_i.clk_en && !cfg_i.sw_rst));

  assert_fs_mask_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_fs_o || out_fe_o) |-> $past($onehot(cfg_i.fs_mask)));

  assert_ls_mask_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_ls_o || out_le_o) |-> $past($onehot(cfg_i.ls_mask)));

  assert_one_cycle_pass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($past(in_valid_i) && out_data_o == $past(in_data_i)
                     && out_vc_o == $past(in_vc_i)));
endmodule

bind cam_win_filter cwf_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_i       (cfg),
  .in_valid_i  (in_valid_i),
  .in_vc_i     (in_vc_i),
  .in_cls_i    (in_cls_i),
  .in_data_i   (in_data_i),
  .out_valid_o (out_valid_o),
  .out_vc_o    (out_vc_o),
  .out_data_o  (out_data_o),
  .out_fs_o    (out_fs_o),
  .out_fe_o    (out_fe_o),
  .out_ls_o    (out_ls_o),
  .out_le_o    (out_le_o)
);

// File: tb/tb_cam_win_filter.sv
`timescale 1ns/1ps
module tb_cam_win_filter;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic          iv = 1'b0;
  logic [1:0]    ivc = '0;
  logic [2:0]    icls = '0;
  logic          isof = 1'b0, isol = 1'b0;
  logic [DW-1:0] idata = '0;
  logic          ov, ofs, ofe, ols, ole;
  logic [1:0]    ovc;
  logic [DW-1:0] odata;

  always #2.5 clk = ~clk;

  cam_win_filter #(.DATA_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .in_valid_i(iv), .in_vc_i(ivc), .in_cls_i(icls), .in_sof_i(isof), .in_sol_i(isol),
    .in_data_i(idata), .out_valid_o(ov), .out_vc_o(ovc), .out_data_o(odata),
    .out_fs_o(ofs), .out_fe_o(ofe), .out_ls_o(ols), .out_le_o(ole)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // bench copy of the programmed configuration
  bit          b_srst = 0, b_clken = 0;
  bit [3:0]    b_chen = 0;
  bit [4:0]    b_clsen = 0;
  bit [15:0]   b_xs = 0, b_xe = 0, b_ys = 0, b_ye = 0;
  bit [3:0]    b_fsm = 0, b_lsm = 0;
  // per-channel position model
  bit [15:0]   m_col [4];
  bit [15:0]   m_row [4];
  bit          m_fr  [4];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int c = 0; c < 4; c++) begin
      m_col[c] = 0; m_row[c] = 0; m_fr[c] = 0;
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d; iv = 1'b0;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_ctrl(bit srst, bit clken);
    b_srst = srst; b_clken = clken;
    if (srst) clear_model();
    wr(3'd0, {30'd0, clken, srst});
  endtask

  task automatic set_gen(bit [3:0] ch, bit [4:0] cls);
    b_chen = ch; b_clsen = cls;
    wr(3'd1, {11'd0, cls, 12'd0, ch});
  endtask

  task automatic set_win(bit [15:0] xs, bit [15:0] xe, bit [15:0] ys, bit [15:0] ye);
    b_xs = xs; b_xe = xe; b_ys = ys; b_ye = ye;
    wr(3'd2, {xe, xs});
    wr(3'd3, {ye, ys});
  endtask

  task automatic set_sync(bit [3:0] fsm, bit [3:0] lsm);
    b_fsm = fsm; b_lsm = lsm;
    wr(3'd4, {8'd0, lsm, fsm, 16'd0});
  endtask

  // one beat: drive, predict from the bench model, compare one clock later
  task automatic beat(bit [1:0] vc, bit [2:0] cls, bit sof, bit sol, bit [DW-1:0] d, string tag);
    bit acc, live, win, ev, efs, efe, els, ele, fsok, lsok;
    bit [15:0] c, r;
    iv = 1'b1; ivc = vc; icls = cls; isof = sof; isol = sol; idata = d;
    acc = b_clken && !b_srst && b_chen[vc] && (cls < 5) && b_clsen[cls];
    if (sof) begin c = 0; r = 0; end
    else if (sol) begin c = 0; r = m_row[vc] + 16'd1; end
    else begin c = m_col[vc] + 16'd1; r = m_row[vc]; end
    live = sof || m_fr[vc];
    if (acc) begin
      m_col[vc] = c; m_row[vc] = r;
      if (sof) m_fr[vc] = 1;
    end
    win  = (c >= b_xs) && (c <= b_xe) && (r >= b_ys) && (r <= b_ye);
    ev   = acc && live && win;
    fsok = ($countones(b_fsm) == 1) && b_fsm[vc];
    lsok = ($countones(b_lsm) == 1) && b_lsm[vc];
    efs  = ev && fsok && c == b_xs && r == b_ys;
    efe  = ev && fsok && c == b_xe && r == b_ye;
    els  = ev && lsok && c == b_xs;
    ele  = ev && lsok && c == b_xe;
    @(negedge clk);
    iv = 1'b0;
    begin
      logic [31:0] act, exp;
      act = {ov, ofs, ofe, ols, ole, (ov ? {ovc, odata} : 14'd0), 13'd0};
      exp = {ev, efs, efe, els, ele, (ev ? {vc, d} : 14'd0), 13'd0};
      chk(act === exp, tag, act, exp);
    end
  endtask

  task automatic frame(bit [1:0] vc, bit [2:0] cls, int w, int h, string tag);
    for (int r = 0; r < h; r++)
      for (int c = 0; c < w; c++)
        beat(vc, cls, (r == 0 && c == 0), (c == 0 && r != 0), DW'($urandom), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1337));
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state and default configuration forwards nothing
    chk({ov, ofs, ofe, ols, ole} === 5'b0, "R1 reset outputs", {27'd0, ov, ofs, ofe, ols, ole}, 0);
    frame(2'd0, 3'd0, 4, 3, "R1");

    // bring-up: soft reset, release, then clock enable (R9)
    set_ctrl(1, 0);
    set_ctrl(0, 0);
    frame(2'd0, 3'd0, 3, 2, "R9 clock off");
    set_ctrl(0, 1);
    set_gen(4'b0001, 5'b00001);
    set_win(16'd2, 16'd5, 16'd1, 16'd2);
    set_sync(4'b0001, 4'b0001);
    frame(2'd0, 3'd0, 8, 4, "R4 R6 R7");

    // R2: disabled channel dropped, then enabled
    frame(2'd1, 3'd0, 8, 4, "R2 disabled");
    set_gen(4'b0011, 5'b00001);
    frame(2'd1, 3'd0, 8, 4, "R2 enabled no sync");

    // R3: YUV class gated by its own bit, out-of-range class dropped
    frame(2'd0, 3'd1, 8, 4, "R3 yuv off");
    set_gen(4'b0011, 5'b00011);
    frame(2'd0, 3'd1, 8, 4, "R3 yuv on");
    frame(2'd0, 3'd6, 8, 4, "R3 bad class");

    // R8: non-one-hot masks give no sync
    set_sync(4'b0011, 4'b0000);
    frame(2'd0, 3'd0, 8, 4, "R8");
    set_sync(4'b0001, 4'b0001);

    // R4 boundary: single-pixel window at origin, wide window edge
    set_win(16'd0, 16'd0, 16'd0, 16'd0);
    frame(2'd0, 3'd0, 3, 2, "R4 one pixel");
    set_win(16'd0, 16'd6, 16'd0, 16'd2);
    frame(2'd0, 3'd0, 7, 3, "R4 full");

    // R5: no frame start on channel 2 yet
    set_gen(4'b0111, 5'b00001);
    for (int i = 0; i < 4; i++) beat(2'd2, 3'd0, 0, 0, DW'(i), "R5 before sof");
    // R5: interleaved channels keep separate positions
    beat(2'd0, 3'd0, 1, 0, 12'h100, "R5 interleave");
    beat(2'd1, 3'd0, 1, 0, 12'h200, "R5 interleave");
    for (int i = 0; i < 6; i++) begin
      beat(2'd0, 3'd0, 0, 0, DW'(i), "R5 interleave");
      beat(2'd1, 3'd0, 0, 0, DW'(i + 8), "R5 interleave");
    end

    // R9: clock off holds position, soft reset drops frame state
    beat(2'd0, 3'd0, 1, 0, 12'h011, "R9");
    beat(2'd0, 3'd0, 0, 0, 12'h012, "R9");
    set_ctrl(0, 0);
    beat(2'd0, 3'd0, 0, 0, 12'h013, "R9 clock off");
    set_ctrl(0, 1);
    beat(2'd0, 3'd0, 0, 0, 12'h014, "R9 resume");
    set_ctrl(1, 1);
    beat(2'd0, 3'd0, 0, 0, 12'h015, "R9 in reset");
    set_ctrl(0, 1);
    beat(2'd0, 3'd0, 0, 0, 12'h016, "R9 no sof");
    frame(2'd0, 3'd0, 5, 2, "R9 new frame");

    // randomized section, R10 latency on every beat
    for (int blk = 0; blk < 12; blk++) begin
      bit [15:0] xs, ys;
      bit [3:0] opt [6] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b0000};
      xs = 16'($urandom_range(0, 6));
      ys = 16'($urandom_range(0, 3));
      set_gen(4'($urandom), 5'($urandom) | 5'b00001);
      set_win(xs, xs + 16'($urandom_range(0, 5)), ys, ys + 16'($urandom_range(0, 3)));
      set_sync(opt[$urandom_range(0, 5)], opt[$urandom_range(0, 5)]);
      for (int k = 0; k < 300; k++) begin
        bit s, l;
        s = ($urandom_range(0, 19) == 0);
        l = !s && ($urandom_range(0, 7) == 0);
        if ($urandom_range(0, 9) == 0) begin
          @(negedge clk);
          chk(ov === 1'b0, "R10 idle", {31'd0, ov}, 0);
        end
        beat(2'($urandom), ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'($urandom_range(0, 1)),
             s, l, DW'($urandom), "R10 random");
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule